// File: doc/BRIEF.md
# Row-Column Static RAM

This block is a 1024-word by 4-bit static memory. Its cells are kept as a square matrix rather than a tall, narrow array. The 10-bit address is split in two. The upper six bits choose one of 64 rows. The lower four bits choose one of 16 positions along that row. Each data bit lives in its own 64x16 slice, so one row across all four slices forms a 64-bit line.

Two active-low control pins set what happens at each rising clock edge:

- A write stores the word on the input side of the data bus.
- A read places the addressed word on the output side one clock later and asserts the output-enable.
- With chip select high, the memory is idle.

The bus is shared in direction. It is modelled as a driven output vector plus an output-enable. While the enable is low the bus is released and the output vector is held at zero.

The block takes at most one access per cycle and never stalls. For that reason it has no valid/ready handshake: a caller may present a new access on every clock, with no back-pressure.

Top module: `sram_rc_top`

## Requirements
- R1: After reset, `data_oe` is 0 and `data_out` is 0. Reset does not alter stored words.
- R2: With `cs_n`=0 and `we_n`=1 at a rising edge, `data_oe` is 1 and `data_out` holds the stored word at `addr` right after that edge.
- R3: With `cs_n`=0 and `we_n`=0 at a rising edge, `data_in` is stored at `addr`, and `data_oe` is 0 right after that edge.
- R4: With `cs_n`=1 at a rising edge, nothing is stored whatever `we_n` and `data_in` are, and `data_oe` is 0 after that edge.
- R5: Whenever `data_oe` is 0, `data_out` is all zeros (bus released).
- R6: `addr[9:4]` selects the row and `addr[3:0]` the column. A write changes only its own word: the other 15 words of its row and the same column in other rows keep their values.
- R7: The bus turns around with no dead cycle. A write directly after a read drops `data_oe` after the write edge. A read directly after a write to the same address returns the new word.
- R8: During any access exactly one row select and exactly one column select are active. While idle, no row select is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low (read when high) |
| addr | input | 10 | Word address: row in [9:4], column in [3:0] |
| data_in | input | 4 | Input side of the shared data bus |
| data_out | output | 4 | Output side of the shared data bus, zero when released |
| data_oe | output | 1 | Bus drive enable, high only after a read |

## Verification
The bench builds the block with its default parameters: six row bits, four column bits and four data bits. That is the full 64x64 matrix, so every row select, every column select and every slice is reachable.

A sweep writes all 1024 words. Random traffic then concentrates part of its addresses on one row, which brings neighbouring-column disturbance and back-to-back read/write turnaround within reach. Directed cases add idle cycles with write enable low and a reset in the middle of a read.

// File: rtl/sram_rc_pkg.sv
package sram_rc_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_t;

  // Control truth table: chip select dominates, then write enable picks direction.
  function automatic acc_kind_t decode_acc(input logic cs_n, input logic we_n);
    if (cs_n)      return ACC_IDLE;
    else if (we_n) return ACC_READ;
    else           return ACC_WRITE;
  endfunction

endpackage

// File: rtl/sram_rc_dec.sv
module sram_rc_dec #(
  parameter int SEL_BITS = 4,
  localparam int LINES   = 1 << SEL_BITS
) (
  input  logic                en,
  input  logic [SEL_BITS-1:0] code,
  output logic [LINES-1:0]    onehot
);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign onehot[i] = en && (code == SEL_BITS'(i));
  end

endmodule

// File: rtl/sram_rc_ctrl.sv
module sram_rc_ctrl
  import sram_rc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic we_n,
  output logic acc_en,
  output logic rd_en,
  output logic wr_en,
  output logic oe_q
);

  acc_kind_t kind;

  always_comb begin
    kind   = decode_acc(cs_n, we_n);
    acc_en = (kind != ACC_IDLE);
    rd_en  = (kind == ACC_READ);
    wr_en  = (kind == ACC_WRITE);
  end

  // The output enable follows the access kind of the previous edge only.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_q <= 1'b0;
    else        oe_q <= rd_en;
  end

endmodule

// File: rtl/sram_rc_slice.sv
module sram_rc_slice #(
  parameter int ROWS = 64,
  parameter int COLS = 16
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [ROWS-1:0] row_sel,
  input  logic [COLS-1:0] col_sel,
  input  logic            wr_bit,
  output logic            rd_bit
);

  logic [COLS-1:0] cells [ROWS];
  logic [COLS-1:0] line;

  // Only the cell at the crossing of the selected row and column is written.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int r = 0; r < ROWS; r++) begin
        if (row_sel[r]) begin
          for (int c = 0; c < COLS; c++) begin
            if (col_sel[c]) cells[r][c] <= wr_bit;
          end
        end
      end
    end
  end

  // Row multiplexer builds the selected line, column multiplexer picks one bit.
  always_comb begin
    line = '0;
    for (int r = 0; r < ROWS; r++) begin
      line = line | (cells[r] & {COLS{row_sel[r]}});
    end
    rd_bit = |(line & col_sel);
  end

endmodule

// File: rtl/sram_rc_top.sv
module sram_rc_top #(
  parameter int ROW_BITS  = 6,
  parameter int COL_BITS  = 4,
  parameter int DATA_BITS = 4,
  localparam int ADDR_BITS = ROW_BITS + COL_BITS,
  localparam int ROWS      = 1 << ROW_BITS,
  localparam int COLS      = 1 << COL_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 we_n,
  input  logic [ADDR_BITS-1:0] addr,
  input  logic [DATA_BITS-1:0] data_in,
  output logic [DATA_BITS-1:0] data_out,
  output logic                 data_oe
);

  logic                 acc_en;
  logic                 rd_en;
  logic                 wr_en;
  logic [ROWS-1:0]      row_sel;
  logic [COLS-1:0]      col_sel;
  logic [DATA_BITS-1:0] rd_word;

  sram_rc_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .we_n   (we_n),
    .acc_en (acc_en),
    .rd_en  (rd_en),
    .wr_en  (wr_en),
    .oe_q   (data_oe)
  );

  sram_rc_dec #(.SEL_BITS(ROW_BITS)) u_row_dec (
    .en     (acc_en),
    .code   (addr[ADDR_BITS-1:COL_BITS]),
    .onehot (row_sel)
  );

  sram_rc_dec #(.SEL_BITS(COL_BITS)) u_col_dec (
    .en     (acc_en),
    .code   (addr[COL_BITS-1:0]),
    .onehot (col_sel)
  );

  for (genvar b = 0; b < DATA_BITS; b++) begin : g_slice
    sram_rc_slice #(.ROWS(ROWS), .COLS(COLS)) u_slice (
      .clk     (clk),
      .wr_en   (wr_en),
      .row_sel (row_sel),
      .col_sel (col_sel),
      .wr_bit  (data_in[b]),
      .rd_bit  (rd_word[b])
    );
  end

  // Registered output stage models access time; released bus is held at zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     data_out <= '0;
    else if (rd_en) data_out <= rd_word;
    else            data_out <= '0;
  end

endmodule

// File: rtl/sram_rc_checker.sv
module sram_rc_checker #(
  parameter int ROWS      = 64,
  parameter int COLS      = 16,
  parameter int DATA_BITS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cs_n,
  input logic                 we_n,
  input logic [DATA_BITS-1:0] data_out,
  input logic                 data_oe,
  input logic [ROWS-1:0]      row_sel,
  input logic [COLS-1:0]      col_sel
);

  assert_read_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && we_n) |=> data_oe);

  assert_write_releases_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !we_n) |=> !data_oe);

  assert_idle_releases_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !data_oe);

  assert_released_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> (data_out == '0));

  assert_one_row_one_col_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> ($countones(row_sel) == 1 && $countones(col_sel) == 1));

  assert_idle_no_row_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> $onehot0(row_sel) && (row_sel == '0));

endmodule

bind sram_rc_top sram_rc_checker #(
  .ROWS(ROWS), .COLS(COLS), .DATA_BITS(DATA_BITS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .we_n     (we_n),
  .data_out (data_out),
  .data_oe  (data_oe),
  .row_sel  (row_sel),
  .col_sel  (col_sel)
);

// File: tb/sram_rc_top_tb.sv
module sram_rc_top_tb;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       we_n = 1'b1;
  logic [9:0] addr = '0;
  logic [3:0] data_in = '0;
  logic [3:0] data_out;
  logic       data_oe;

  int checks = 0;
  int fails  = 0;
  logic [3:0] model [1024];

  always #(CLK_P/2) clk = ~clk;

  sram_rc_top u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n),
    .addr(addr), .data_in(data_in), .data_out(data_out), .data_oe(data_oe)
  );

  function automatic logic [3:0] pattern(input logic [9:0] a);
    return a[3:0] ^ a[9:6] ^ {a[4], a[5], a[4], a[5]};
  endfunction

  task automatic check(input string tag, input logic [4:0] got, input logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got oe/data=%b expected %b", tag, got, exp);
    end
  endtask

  // Called at a falling edge: drives one access, waits one edge, checks outputs.
  task automatic step(input logic cs, input logic we, input logic [9:0] a,
                      input logic [3:0] d, input string tag);
    logic [4:0] exp;
    cs_n = cs; we_n = we; addr = a; data_in = d;
    @(posedge clk);
    @(negedge clk);
    if (!cs && we)      exp = {1'b1, model[a]};
    else                exp = 5'b0;
    if (!cs && !we) model[a] = d;
    check(tag, {data_oe, data_out}, exp);
  endtask

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    check("R1 reset", {data_oe, data_out}, 5'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // Fill every word (R3), then read a few back (R2).
    for (int a = 0; a < 1024; a++) step(1'b0, 1'b0, 10'(a), pattern(10'(a)), "R3 fill");
    for (int a = 0; a < 1024; a += 37) step(1'b0, 1'b1, 10'(a), 4'h0, "R2 read");

    // Row/column isolation around address row 21, column 5 (R6).
    step(1'b0, 1'b0, {6'd21, 4'd5}, ~pattern({6'd21, 4'd5}), "R6 write");
    for (int c = 0; c < 16; c++) step(1'b0, 1'b1, {6'd21, 4'(c)}, 4'h0, "R6 row");
    for (int r = 0; r < 64; r += 5) step(1'b0, 1'b1, {6'(r), 4'd5}, 4'h0, "R6 col");
    check("R6 target", {1'b0, model[{6'd21, 4'd5}]}, {1'b0, ~pattern({6'd21, 4'd5})});

    // Idle with write enable low must store nothing (R4).
    step(1'b1, 1'b0, 10'h2A7, ~pattern(10'h2A7), "R4 idle");
    step(1'b1, 1'b1, 10'h2A7, 4'hF, "R4 idle");
    step(1'b0, 1'b1, 10'h2A7, 4'h0, "R4 readback");
    check("R4 unchanged", {1'b0, model[10'h2A7]}, {1'b0, pattern(10'h2A7)});

    // Turnaround: read, write, read the same word (R7).
    step(1'b0, 1'b1, 10'h3FF, 4'h0, "R7 read");
    step(1'b0, 1'b0, 10'h3FF, 4'h9, "R7 write");
    step(1'b0, 1'b1, 10'h3FF, 4'h0, "R7 readnew");
    check("R7 value", {data_oe, data_out}, 5'b1_1001);
    step(1'b0, 1'b0, 10'h000, 4'h6, "R7 write");
    step(1'b0, 1'b1, 10'h000, 4'h0, "R7 readnew");

    // Reset during a read releases the bus but keeps contents (R1).
    cs_n = 1'b0; we_n = 1'b1; addr = 10'h155;
    @(posedge clk); @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 midreset", {data_oe, data_out}, 5'b0);
    cs_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    step(1'b0, 1'b1, 10'h155, 4'h0, "R1 retained");

    // Constrained random traffic, a quarter of it inside row 9 (R2 R3 R4 R5 R7).
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      logic [9:0]  a;
      r = $urandom;
      a = (r[9:8] == 2'b00) ? {6'd9, r[3:0]} : 10'($urandom_range(0, 1023));
      step(r[12:10] == 3'd0, r[13], a, 4'($urandom), "R5 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule